// File: doc/BRIEF.md
# FSM State Upset Detector with Recovery State

This block holds the state register of a finite state machine and checks it every cycle for a single-bit upset. The surrounding FSM supplies its next-state value. The block registers that value and presents the stored state. It also raises a flag whenever the stored vector can no longer be trusted. The block only detects upsets; it never repairs them in place. In the cycle after a detection it loads a recovery state fixed by a parameter. A correct parity value is loaded with that state, so the machine resumes from a known point.

A parameter picks one of two checking methods:

- **Parity mode.** Two check bits are stored next to the state. Both are computed from the incoming next state: one is its odd parity and the other its even parity. Each cycle the block recomputes both bits from the stored state. It reports an upset only when both stored bits disagree with the recomputed ones.
- **One-hot mode.** The FSM uses one-hot encoding, so no check bits are kept. Any stored vector that does not have exactly one bit set counts as an upset.

Top module: `fsm_upset_guard`

## Requirements
- R1: While `rst` is high, each rising edge loads `RESET_STATE` together with parity bits that match it. In the first cycle after `rst` falls, `state_o` equals `RESET_STATE` and `upset_o` is low.
- R2: While no upset is flagged, each rising edge copies `nxt_state_i` into the stored state, and `state_o` shows it in the following cycle.
- R3: In parity mode, inverting one bit of the stored state raises `upset_o` in that same cycle, without waiting for a clock edge. `state_o` shows the corrupted value during that cycle.
- R4: When `upset_o` is high at a rising edge, that edge loads `RECOVERY` and discards `nxt_state_i`. After that edge, `state_o` equals `RECOVERY`.
- R5: In parity mode, a mismatch in only one of the two stored parity bits is not an upset. `upset_o` stays low and the next edge still loads `nxt_state_i`. Stored bit 0 holds the odd parity of the state (the XNOR of its bits). Stored bit 1 holds the even parity (the XOR of its bits).
- R6: In one-hot mode, a stored value with zero bits set or with two or more bits set raises `upset_o`. Examples are 0000 and 0101 for a 4-bit state.
- R7: In one-hot mode, a stored value with exactly one bit set never raises `upset_o`. This holds for 0001, 0010, 0100 and 1000.
- R8: `upset_o` stays high for one cycle only. The recovery edge also loads matching parity, so `upset_o` is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nxt_state_i | input | W | Next state from the FSM's transition logic |
| state_o | output | W | Stored present state, shown exactly as held |
| upset_o | output | 1 | High during any cycle in which the stored state fails its check |

## Verification
A corrupted state register or parity register shows up at the ports without waiting for a clock edge. In parity mode, `upset_o` rises in the same cycle that a state bit flips. In one-hot mode, it rises as soon as the stored vector stops being one-hot. One edge later, `state_o` must equal `RECOVERY` and `upset_o` must be low. A wrong parity reload would show as a flag that stays high, and a missed recovery as a state that keeps following the input. A parity-only corruption is a separate case: it must leave both outputs undisturbed. Faults are injected into the stored state and parity bits by forcing them, and the outputs are compared one cycle at a time.

// File: rtl/fsm_guard_pkg.sv
package fsm_guard_pkg;

  typedef enum logic {
    GUARD_PARITY = 1'b0,
    GUARD_ONEHOT = 1'b1
  } guard_mode_e;

  localparam int GUARD_MAXW = 64;

  // Odd parity check bit: makes the total number of ones odd.
  function automatic logic odd_par(input logic [GUARD_MAXW-1:0] v);
    return ~(^v);
  endfunction

  // Even parity check bit: makes the total number of ones even.
  function automatic logic even_par(input logic [GUARD_MAXW-1:0] v);
    return ^v;
  endfunction

  // True when exactly one bit is set.
  function automatic logic is_onehot(input logic [GUARD_MAXW-1:0] v);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < GUARD_MAXW; i++) ones += int'(v[i]);
    return ones == 1;
  endfunction

endpackage

// File: rtl/fsm_guard_detect.sv
module fsm_guard_detect
  import fsm_guard_pkg::*;
#(
  parameter int          W    = 4,
  parameter guard_mode_e MODE = GUARD_PARITY
) (
  input  logic [W-1:0] state_i,
  input  logic [1:0]   par_i,
  output logic         upset_o
);

  localparam int PADW = GUARD_MAXW - W;

  logic [GUARD_MAXW-1:0] state_ext;
  assign state_ext = {{PADW{1'b0}}, state_i};

  generate
    if (MODE == GUARD_PARITY) begin : g_parity
      logic odd_miss;
      logic even_miss;
      assign odd_miss  = par_i[0] != odd_par(state_ext);
      assign even_miss = par_i[1] != even_par(state_ext);
      // Only a disagreement on both check bits is a state upset.
      assign upset_o   = odd_miss && even_miss;
    end else begin : g_onehot
      logic unused_par;
      assign unused_par = ^par_i;
      assign upset_o    = !is_onehot(state_ext);
    end
  endgenerate

endmodule

// File: rtl/fsm_guard_store.sv
module fsm_guard_store
  import fsm_guard_pkg::*;
#(
  parameter int           W           = 4,
  parameter guard_mode_e  MODE        = GUARD_PARITY,
  parameter logic [W-1:0] RESET_STATE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] state_q,
  output logic [1:0]   par_q
);

  localparam int PADW = GUARD_MAXW - W;

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_STATE;
    else     state_q <= load_i;
  end

  generate
    if (MODE == GUARD_PARITY) begin : g_par
      logic [GUARD_MAXW-1:0] load_ext;
      logic [GUARD_MAXW-1:0] rst_ext;
      assign load_ext = {{PADW{1'b0}}, load_i};
      assign rst_ext  = {{PADW{1'b0}}, RESET_STATE};
      always_ff @(posedge clk) begin
        if (rst) par_q <= {even_par(rst_ext), odd_par(rst_ext)};
        else     par_q <= {even_par(load_ext), odd_par(load_ext)};
      end
    end else begin : g_nopar
      assign par_q = '0;
    end
  endgenerate

endmodule

// File: rtl/fsm_upset_guard.sv
module fsm_upset_guard
  import fsm_guard_pkg::*;
#(
  parameter int           W           = 4,
  parameter guard_mode_e  MODE        = GUARD_PARITY,
  parameter logic [W-1:0] RESET_STATE = 4'b0001,
  parameter logic [W-1:0] RECOVERY    = 4'b1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_state_i,
  output logic [W-1:0] state_o,
  output logic         upset_o
);

  logic [W-1:0] state_q;
  logic [1:0]   par_q;
  logic         upset_det;
  logic [W-1:0] load_state;

  fsm_guard_detect #(.W(W), .MODE(MODE)) u_det (
    .state_i (state_q),
    .par_i   (par_q),
    .upset_o (upset_det)
  );

  // A flagged state is never trusted: the next edge goes to recovery.
  assign load_state = upset_det ? RECOVERY : nxt_state_i;

  fsm_guard_store #(.W(W), .MODE(MODE), .RESET_STATE(RESET_STATE)) u_store (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_state),
    .state_q (state_q),
    .par_q   (par_q)
  );

  assign state_o = state_q;
  assign upset_o = upset_det;

endmodule

// File: rtl/fsm_upset_guard_chk.sv
module fsm_upset_guard_chk
  import fsm_guard_pkg::*;
#(
  parameter int           W           = 4,
  parameter guard_mode_e  MODE        = GUARD_PARITY,
  parameter logic [W-1:0] RESET_STATE = 4'b0001,
  parameter logic [W-1:0] RECOVERY    = 4'b1000
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] nxt_i,
  input logic [W-1:0] state_i,
  input logic         upset_i
);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_i == RESET_STATE && !upset_i)); // R1

  AST_FOLLOW_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upset_i) && !upset_i) |-> state_i == $past(nxt_i)); // R2

  AST_GO_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    upset_i |=> state_i == RECOVERY); // R4

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    upset_i |=> !upset_i); // R8

  generate
    if (MODE == GUARD_ONEHOT) begin : g_oh
      AST_ONEHOT_VALID: assert property (@(posedge clk) disable iff (rst)
        !upset_i |-> $countones(state_i) == 1); // R6
      AST_ONEHOT_FLAG: assert property (@(posedge clk) disable iff (rst)
        $countones(state_i) == 1 |-> !upset_i); // R7
    end
  endgenerate

endmodule

bind fsm_upset_guard fsm_upset_guard_chk #(
  .W(W), .MODE(MODE), .RESET_STATE(RESET_STATE), .RECOVERY(RECOVERY)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .nxt_i   (nxt_state_i),
  .state_i (state_o),
  .upset_i (upset_o)
);

// File: tb/fsm_upset_guard_bench.sv
module fsm_upset_guard_bench;
  import fsm_guard_pkg::*;

  localparam logic [3:0] P_RST = 4'b0011;
  localparam logic [3:0] P_REC = 4'b1010;
  localparam logic [3:0] H_RST = 4'b0001;
  localparam logic [3:0] H_REC = 4'b1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nxt_p = P_RST;
  logic [3:0] nxt_h = H_RST;
  logic [3:0] st_p, st_h;
  logic       up_p, up_h;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fsm_upset_guard #(.W(4), .MODE(GUARD_PARITY), .RESET_STATE(P_RST), .RECOVERY(P_REC))
    u_fsm_upset_guard (.clk(clk), .rst(rst), .nxt_state_i(nxt_p), .state_o(st_p), .upset_o(up_p));

  fsm_upset_guard #(.W(4), .MODE(GUARD_ONEHOT), .RESET_STATE(H_RST), .RECOVERY(H_REC))
    u_fsm_upset_guard_oh (.clk(clk), .rst(rst), .nxt_state_i(nxt_h), .state_o(st_h), .upset_o(up_h));

  typedef struct {
    bit         sel;   // 0 parity instance, 1 one-hot instance
    logic [3:0] st;
    logic       up;
    string      tag;
  } exp_t;

  exp_t sb[$];
  logic [3:0] bad;

  task automatic check(input string tag, input logic [3:0] a_st, input logic a_up,
                       input logic [3:0] e_st, input logic e_up);
    checks++;
    if (a_st !== e_st || a_up !== e_up) begin
      errors++;
      $display("FAIL %s state=%b upset=%b expected state=%b upset=%b",
               tag, a_st, a_up, e_st, e_up);
    end
  endtask

  // Driver: present a next state and queue what must appear after the edge.
  task automatic step(input bit sel, input logic [3:0] v, input logic [3:0] e_st,
                      input logic e_up, input string tag);
    exp_t it;
    @(negedge clk);
    if (sel) nxt_h = v; else nxt_p = v;
    it.sel = sel; it.st = e_st; it.up = e_up; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare queued expectations shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        if (it.sel) check(it.tag, st_h, up_h, it.st, it.up);
        else        check(it.tag, st_p, up_p, it.st, it.up);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 parity reset", st_p, up_p, P_RST, 1'b0);
    check("R1 onehot reset", st_h, up_h, H_RST, 1'b0);

    // Parity mode, normal flow
    step(0, 4'h5, 4'h5, 1'b0, "R2 load 0101");
    step(0, 4'h9, 4'h9, 1'b0, "R2 load 1001");
    step(0, 4'hE, 4'hE, 1'b0, "R2 load 1110");
    step(0, 4'h0, 4'h0, 1'b0, "R2 load 0000");
    step(0, 4'hF, 4'hF, 1'b0, "R2 load 1111");

    // R3: flip one stored state bit (state is 1111)
    @(negedge clk);
    bad = 4'hF ^ 4'b0100;
    force u_fsm_upset_guard.u_store.state_q = bad;
    #1;
    check("R3 flip detected", st_p, up_p, bad, 1'b1);
    release u_fsm_upset_guard.u_store.state_q;
    nxt_p = 4'h6;
    begin
      exp_t it;
      it.sel = 0; it.st = P_REC; it.up = 1'b0; it.tag = "R4 parity recovery, R8 flag clears";
      sb.push_back(it);
    end
    step(0, 4'h3, 4'h3, 1'b0, "R2 after recovery");

    // R5: corrupt only the odd-parity check bit (state 0011: odd=1, even=0)
    @(negedge clk);
    force u_fsm_upset_guard.u_store.par_q = 2'b00;
    #1;
    check("R5 single parity mismatch ignored", st_p, up_p, 4'h3, 1'b0);
    release u_fsm_upset_guard.u_store.par_q;
    nxt_p = 4'h7;
    begin
      exp_t it;
      it.sel = 0; it.st = 4'h7; it.up = 1'b0; it.tag = "R5 next state still loaded";
      sb.push_back(it);
    end

    // One-hot mode
    step(1, 4'b0010, 4'b0010, 1'b0, "R7 one-hot 0010");
    step(1, 4'b0100, 4'b0100, 1'b0, "R7 one-hot 0100");
    step(1, 4'b1000, 4'b1000, 1'b0, "R7 one-hot 1000");
    step(1, 4'b0001, 4'b0001, 1'b0, "R7 one-hot 0001");
    step(1, 4'b0101, 4'b0101, 1'b1, "R6 two bits set");
    step(1, 4'b0010, H_REC,   1'b0, "R4 onehot recovery, R8 flag clears");
    step(1, 4'b0000, 4'b0000, 1'b1, "R6 no bit set");
    step(1, 4'b0100, H_REC,   1'b0, "R4 onehot recovery after zero");
    step(1, 4'b1111, 4'b1111, 1'b1, "R6 all bits set");
    step(1, 4'b0010, H_REC,   1'b0, "R4 onehot recovery after 1111");
    step(1, 4'b0010, 4'b0010, 1'b0, "R2 onehot resumes");

    repeat (3) @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule